// File: doc/BRIEF.md
# Conditional Branch Target Unit

This block resolves a short conditional branch for the instruction sequencer. It takes the address of the branch being executed, the 16-bit branch instruction word and the processor status flags. From these it produces the address of the next instruction, a flag that tells whether the branch was taken, and a trap request. The sequencer uses these to steer fetch. Fetching the instruction and flushing the pipeline are handled by the neighbouring logic.

The branch offset is split across two fields of the instruction word that are not next to each other. The block joins them into a signed, even, 9-bit displacement and extends it to the address width. A 4-bit condition code selects a test of the zero, sign, overflow, carry and saturation flags. A branch that is always taken and has an offset of zero would jump to itself forever. This encoding is reserved: the block does not execute it as a branch and asserts a trap request instead.

With the default setting the three results are registered, so they appear one clock after the inputs. A parameter removes the register stage and makes the block purely combinational.

Top module: `brtu_top`

## Requirements
- R1: The branch word is split into fields as follows: bits 15:11 are the high offset field H, bits 6:4 are the low offset field L, and bits 3:0 are the condition code. The displacement is H*16 + L*2, read as a 9-bit two's-complement value and sign-extended to the address width, which gives the range -256 to +254.
- R2: Bit 0 of the displacement is always zero, so a taken target always differs from the current address by an even amount.
- R3: When the branch is taken, the next address is the current address plus the displacement, wrapping modulo 2^32.
- R4: When the branch is not taken, the next address is the current address plus 2, wrapping modulo 2^32.
- R5: When H=0, L=0 and the code is 5, the trap output is 1, the taken output is 0 and the next address is the current address plus 2. No other word raises a trap.
- R6: Codes 0 to 7 test the flags as follows. 0 is OV. 1 is CY. 2 is Z. 3 is CY or Z. 4 is S. 5 is always true. 6 is S xor OV. 7 is (S xor OV) or Z.
- R7: Code 13 tests SAT. Each of the other codes from 8 to 15 is the inverse of the code 8 below it.
- R8: Bits 10:7 of the branch word have no effect on any output.
- R9: In the default registered mode, every output reflects the inputs that were present at the previous rising clock edge. While the synchronous active-high reset is applied, all outputs are 0 after the edge.
- R10: A flag that the selected condition code does not test has no effect on the outputs. For example, SAT has no effect under code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| cur_addr | input | 32 | Address of the branch instruction |
| insn_word | input | 16 | Branch instruction word |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_ov | input | 1 | Overflow flag |
| flag_cy | input | 1 | Carry flag |
| flag_sat | input | 1 | Saturation flag |
| next_addr | output | 32 | Address of the next instruction |
| br_taken | output | 1 | The branch is taken |
| trap_req | output | 1 | The reserved self-branch was detected |

## Verification
In the default mode, next_addr, br_taken and trap_req all come due exactly one rising edge after the inputs that produce them. The driver changes the inputs on falling edges and queues the expected triple for each stimulus. The monitor pops and compares one entry 1 ns after every rising edge, which is the first moment that edge's result is visible and well before the next inputs arrive. A separate check samples the outputs between a change of input and the next rising edge to confirm that they hold their old value. A reset applied mid-run is checked on the cycle after its edge.

// File: rtl/brtu_pkg.sv
package brtu_pkg;

    localparam int WORD_W = 16;
    localparam int HI_W   = 5;
    localparam int LO_W   = 3;
    localparam int OPC_W  = 4;
    localparam int CC_W   = 4;
    localparam int DISP_W = HI_W + LO_W + 1;

    // Condition codes; bit 3 selects the inverted sense (except 5 and 13)
    typedef enum logic [CC_W-1:0] {
        CC_OVF  = 4'h0,
        CC_LOW  = 4'h1,
        CC_EQ   = 4'h2,
        CC_NHI  = 4'h3,
        CC_NEG  = 4'h4,
        CC_ALW  = 4'h5,
        CC_LT   = 4'h6,
        CC_LE   = 4'h7,
        CC_NOVF = 4'h8,
        CC_NLOW = 4'h9,
        CC_NE   = 4'hA,
        CC_HI   = 4'hB,
        CC_POS  = 4'hC,
        CC_SATF = 4'hD,
        CC_GE   = 4'hE,
        CC_GT   = 4'hF
    } cc_e;

    // Branch word, MSB first
    typedef struct packed {
        logic [HI_W-1:0]  off_hi;
        logic [OPC_W-1:0] opc;
        logic [LO_W-1:0]  off_lo;
        cc_e              cc;
    } bword_t;

    typedef struct packed {
        logic z;
        logic s;
        logic ov;
        logic cy;
        logic sat;
    } flags_t;

    typedef struct packed {
        logic [31:0] nxt;
        logic        taken;
        logic        trap;
    } result_t;

    // Positive-sense test selected by the low three code bits
    function automatic logic base_test(input logic [2:0] sel, input flags_t f);
        logic lt;
        lt = f.s ^ f.ov;
        case (sel)
            3'd0:    base_test = f.ov;
            3'd1:    base_test = f.cy;
            3'd2:    base_test = f.z;
            3'd3:    base_test = f.cy | f.z;
            3'd4:    base_test = f.s;
            3'd5:    base_test = 1'b1;
            3'd6:    base_test = lt;
            default: base_test = lt | f.z;
        endcase
    endfunction

endpackage

// File: rtl/brtu_disp_asm.sv
module brtu_disp_asm
    import brtu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [HI_W-1:0]   off_hi,
    input  logic [LO_W-1:0]   off_lo,
    output logic [ADDR_W-1:0] disp,
    output logic              zero_off
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [DISP_W-1:0] short_disp;

    always_comb begin
        short_disp = {off_hi, off_lo, 1'b0};
        disp       = {{EXT_W{short_disp[DISP_W-1]}}, short_disp};
        zero_off   = (off_hi == '0) && (off_lo == '0);
    end
endmodule

// File: rtl/brtu_cond_eval.sv
module brtu_cond_eval
    import brtu_pkg::*;
(
    input  cc_e    cc,
    input  flags_t flags,
    output logic   met,
    output logic   is_always
);
    logic base;

    always_comb begin
        base      = base_test(cc[2:0], flags);
        is_always = (cc == CC_ALW);
        if (cc == CC_SATF)
            met = flags.sat;
        else if (is_always)
            met = 1'b1;
        else
            met = base ^ cc[3];
    end
endmodule

// File: rtl/brtu_next_sel.sv
module brtu_next_sel
    import brtu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SEQ_INC = 2
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] disp,
    input  logic              met,
    input  logic              is_always,
    input  logic              zero_off,
    output logic [ADDR_W-1:0] nxt,
    output logic              taken,
    output logic              trap
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(SEQ_INC);

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] tgt_addr;

    always_comb begin
        seq_addr = pc + INC;
        tgt_addr = pc + disp;
        trap     = is_always && zero_off;
        taken    = met && !trap;
        nxt      = taken ? tgt_addr : seq_addr;
    end
endmodule

// File: rtl/brtu_top.sv
module brtu_top
    import brtu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [15:0]       insn_word,
    input  logic              flag_z,
    input  logic              flag_s,
    input  logic              flag_ov,
    input  logic              flag_cy,
    input  logic              flag_sat,
    output logic [ADDR_W-1:0] next_addr,
    output logic              br_taken,
    output logic              trap_req
);
    bword_t            bw;
    flags_t            fl;
    logic [ADDR_W-1:0] disp_c;
    logic              zero_off_c;
    logic              met_c;
    logic              always_c;
    logic [ADDR_W-1:0] next_c;
    logic              taken_c;
    logic              trap_c;
    logic              opc_unused;

    assign bw         = bword_t'(insn_word);
    assign fl         = '{z: flag_z, s: flag_s, ov: flag_ov, cy: flag_cy, sat: flag_sat};
    assign opc_unused = ^bw.opc;

    brtu_disp_asm #(.ADDR_W(ADDR_W)) disp_i (
        .off_hi   (bw.off_hi),
        .off_lo   (bw.off_lo),
        .disp     (disp_c),
        .zero_off (zero_off_c)
    );

    brtu_cond_eval cond_i (
        .cc        (bw.cc),
        .flags     (fl),
        .met       (met_c),
        .is_always (always_c)
    );

    brtu_next_sel #(.ADDR_W(ADDR_W), .SEQ_INC(2)) sel_i (
        .pc        (cur_addr),
        .disp      (disp_c),
        .met       (met_c),
        .is_always (always_c),
        .zero_off  (zero_off_c),
        .nxt       (next_c),
        .taken     (taken_c),
        .trap      (trap_c)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [ADDR_W-1:0] next_q;
            logic              taken_q;
            logic              trap_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    next_q  <= '0;
                    taken_q <= 1'b0;
                    trap_q  <= 1'b0;
                end else begin
                    next_q  <= next_c;
                    taken_q <= taken_c;
                    trap_q  <= trap_c;
                end
            end

            assign next_addr = next_q;
            assign br_taken  = taken_q;
            assign trap_req  = trap_q;

            // R9: outputs follow the previous edge's inputs
            p_reg_follow_r9: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (next_addr == $past(next_c)) && (br_taken == $past(taken_c))
                         && (trap_req == $past(trap_c)));
            // R9: reset clears the outputs
            p_reset_clear_r9: assert property (@(posedge clk)
                rst |=> (next_addr == '0) && !br_taken && !trap_req);
        end else begin : g_comb
            assign next_addr = next_c;
            assign br_taken  = taken_c;
            assign trap_req  = trap_c;
        end
    endgenerate

    // R5: a trap never coexists with a taken branch
    p_trap_blocks_taken_r5: assert property (@(posedge clk) disable iff (rst)
        trap_c |-> !taken_c && (next_c == cur_addr + ADDR_W'(2)));
    // R4: not taken selects the sequential address
    p_seq_addr_r4: assert property (@(posedge clk) disable iff (rst)
        !taken_c |-> (next_c == cur_addr + ADDR_W'(2)));
    // R3: taken selects current address plus displacement
    p_taken_addr_r3: assert property (@(posedge clk) disable iff (rst)
        taken_c |-> (next_c == cur_addr + disp_c));
    // R2: displacement is even
    p_disp_even_r2: assert property (@(posedge clk) disable iff (rst)
        disp_c[0] == 1'b0);
    // R6: always code branches unless trapping
    p_always_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (bw.cc == CC_ALW) && !zero_off_c |-> taken_c);
    // R7: code 13 follows the saturation flag
    p_sat_code_r7: assert property (@(posedge clk) disable iff (rst)
        (bw.cc == CC_SATF) |-> (taken_c == flag_sat));
endmodule

// File: tb/brtu_top_tb_top.sv
`timescale 1ns/1ps
module brtu_top_tb_top;

    typedef struct {
        logic [31:0] nx;
        bit          tk;
        bit          tp;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cur_addr = '0;
    logic [15:0] insn_word = '0;
    logic        flag_z = 0, flag_s = 0, flag_ov = 0, flag_cy = 0, flag_sat = 0;
    logic [31:0] next_addr;
    logic        br_taken;
    logic        trap_req;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    brtu_top dut_i (
        .clk(clk), .rst(rst), .cur_addr(cur_addr), .insn_word(insn_word),
        .flag_z(flag_z), .flag_s(flag_s), .flag_ov(flag_ov), .flag_cy(flag_cy),
        .flag_sat(flag_sat), .next_addr(next_addr), .br_taken(br_taken),
        .trap_req(trap_req)
    );

    function automatic bit ref_met(int code, bit z, bit s, bit ov, bit cy, bit sat);
        case (code)
            0:  return ov;
            1:  return cy;
            2:  return z;
            3:  return cy | z;
            4:  return s;
            5:  return 1'b1;
            6:  return s ^ ov;
            7:  return (s ^ ov) | z;
            8:  return !ov;
            9:  return !cy;
            10: return !z;
            11: return !(cy | z);
            12: return !s;
            13: return sat;
            14: return !(s ^ ov);
            default: return !((s ^ ov) | z);
        endcase
    endfunction

    function automatic exp_t model(logic [31:0] pc, logic [15:0] w, logic [4:0] f, string req);
        exp_t e;
        int   hi, lo, code, off;
        bit   met;
        hi   = int'(w[15:11]);
        lo   = int'(w[6:4]);
        code = int'(w[3:0]);
        off  = hi * 16 + lo * 2;
        if (off >= 256) off = off - 512;
        met  = ref_met(code, f[4], f[3], f[2], f[1], f[0]);
        e.tp = (hi == 0) && (lo == 0) && (code == 5);
        e.tk = met && !e.tp;
        e.nx = e.tk ? pc + 32'(off) : pc + 32'd2;
        e.req = req;
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic apply(logic [31:0] pc, logic [15:0] w, logic [4:0] f);
        cur_addr  = pc;
        insn_word = w;
        {flag_z, flag_s, flag_ov, flag_cy, flag_sat} = f;
    endtask

    // Driver: flags packed as {z,s,ov,cy,sat}
    task automatic drive(logic [31:0] pc, logic [15:0] w, logic [4:0] f, string req);
        @(negedge clk);
        apply(pc, w, f);
        sb.push_back(model(pc, w, f, req));
    endtask

    task automatic drain();
        while (sb.size() != 0) @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    // Monitor: results due 1 ns after the edge that follows the stimulus
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                check((next_addr === e.nx) && (br_taken === e.tk) && (trap_req === e.tp),
                      e.req, "next/taken/trap", {next_addr[29:0], br_taken, trap_req},
                      {e.nx[29:0], e.tk, e.tp});
                if (next_addr !== e.nx)
                    $display("  detail %s next actual=%h expected=%h", e.req, next_addr, e.nx);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        finish_run();
    end

    initial begin
        logic [31:0] pc;
        logic [31:0] hold_nx;
        logic        hold_tk;
        // Reset state (R9)
        rst = 1'b1;
        apply(32'h0000_4000, {5'd4, 4'b1011, 3'd1, 4'd5}, 5'b0);
        repeat (3) @(posedge clk);
        #1;
        check((next_addr === 32'd0) && !br_taken && !trap_req, "R9", "reset outputs",
              next_addr, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Condition codes across all flag patterns (R6, R7)
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 32; f++) begin
                pc = 32'h0001_0000 + 32'(code * 256 + f * 4);
                drive(pc, {5'd5, 4'b1011, 3'd3, 4'(code)}, 5'(f), code < 8 ? "R6" : "R7");
            end
        end

        // Displacement assembly over every field pair, code 5 (R1/R2/R3, R5 at zero)
        for (int hi = 0; hi < 32; hi++) begin
            for (int lo = 0; lo < 8; lo++) begin
                drive(32'h0000_8000 + 32'(hi * 64), {5'(hi), 4'b1011, 3'(lo), 4'd5}, 5'b0,
                      (hi == 0 && lo == 0) ? "R5" : "R1/R2/R3");
            end
        end

        // Wrap-around: taken backward from low address (R3), not taken at top (R4)
        drive(32'h0000_0002, {5'b10000, 4'b1011, 3'd0, 4'd5}, 5'b0, "R3");
        drive(32'hFFFF_FFFE, {5'd1, 4'b1011, 3'd0, 4'd2}, 5'b00000, "R4");
        drive(32'hFFFF_FF80, {5'd15, 4'b1011, 3'd7, 4'd5}, 5'b0, "R3");

        // Trap is independent of flags and opcode bits (R5); zero offset on other codes is not a trap
        drive(32'h0000_1234, {5'd0, 4'b0000, 3'd0, 4'd5}, 5'b11111, "R5");
        drive(32'h0000_1234, {5'd0, 4'b1011, 3'd0, 4'd2}, 5'b10000, "R5");
        drive(32'h0000_1234, {5'd0, 4'b1011, 3'd0, 4'd13}, 5'b00001, "R5");

        // Opcode bits have no effect (R8)
        for (int k = 0; k < 16; k++) begin
            drive(32'h0002_0000 + 32'(k * 16), {5'd9, 4'(k), 3'd5, 4'(k)}, 5'(k * 3), "R8");
        end

        // Untested flags do not matter (R10)
        drive(32'h0003_0000, {5'd2, 4'b1011, 3'd2, 4'd2}, 5'b10001, "R10");
        drive(32'h0003_0000, {5'd2, 4'b1011, 3'd2, 4'd2}, 5'b00001, "R10");
        drive(32'h0003_0000, {5'd2, 4'b1011, 3'd2, 4'd1}, 5'b11100, "R10");
        drive(32'h0003_0000, {5'd2, 4'b1011, 3'd2, 4'd13}, 5'b11110, "R10");

        // Outputs hold until the next edge (R9)
        drain();
        hold_nx = next_addr;
        hold_tk = br_taken;
        @(negedge clk);
        apply(32'h0004_0000, {5'd3, 4'b1011, 3'd0, 4'd5}, 5'b0);
        #1;
        check((next_addr === hold_nx) && (br_taken === hold_tk), "R9", "hold before edge",
              next_addr, hold_nx);
        sb.push_back(model(32'h0004_0000, {5'd3, 4'b1011, 3'd0, 4'd5}, 5'b0, "R9"));

        // Reset mid-run clears outputs (R9)
        drain();
        @(negedge clk);
        rst = 1'b1;
        apply(32'h0005_0000, {5'd6, 4'b1011, 3'd0, 4'd5}, 5'b0);
        @(posedge clk);
        #1;
        check((next_addr === 32'd0) && !br_taken && !trap_req, "R9", "mid-run reset",
              next_addr, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(32'h0005_0000, {5'd6, 4'b1011, 3'd0, 4'd5}, 5'b0, "R9");
        drain();
        finish_run();
    end
endmodule